// File: doc/BRIEF.md
# Soft Mute Gain Ramp

This block sits in a stereo audio datapath and fades the sample stream out and back in without clicks. Each time the mute request changes, a gain level walks from its current value toward zero (mute) or toward unity (unmute), one step per sample strobe. Both channels are scaled by the same gain and registered on the strobe. The ramp takes 1152, 2304 or 4608 sample periods, chosen by a 2-bit speed mode.

An active-low mute-control output drives an external analog muting switch. It falls only once the fade-out has reached zero gain. It rises as soon as the request is withdrawn, before the fade-in has begun. It is also held low while reset, power-down or a clock-ratio error is present.

Top module: `soft_mute_ramp`

## Requirements
- R1: The gain is an integer level L in 0..4608, where 4608 means unity. With `speed` = 2'b00, each strobe moves L by 4, so a full ramp in either direction takes exactly 1152 strobes.
- R2: With `speed` = 2'b01 the step is 2, for a 2304-strobe ramp. With 2'b10 or 2'b11 the step is 1, for a 4608-strobe ramp. The same length applies to fade-out and fade-in.
- R3: If `mute_req` reverses in the middle of a ramp, the level continues from its current value in the new direction, with no jump.
- R4: On every strobe, each output is registered as (in × L') / 4608, truncated toward zero to 24 bits. Here L' is the level after that strobe's step, and the samples are signed two's complement.
- R5: Once the level has reached zero, every output sample is zero.
- R6: While `mute_req` is 1 (mute requested) and the level is nonzero, `mute_ctl_n` stays high. It goes low on the clock after the level reaches zero.
- R7: One clock after `mute_req` returns to 0, `mute_ctl_n` is high, even though the fade-in has not yet advanced (output still zero).
- R8: `mute_ctl_n` is low during reset. It is also low on the clock after `pdn` or `ratio_err` is 1, and it returns high once both clear.
- R9: Reset sets the level to unity and clears both outputs. The first strobe after reset passes samples unchanged.
- R10: Without a strobe, the outputs and the level do not change, whatever the sample inputs or `mute_req` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pdn | input | 1 | Power-down request, forces mute control low |
| ratio_err | input | 1 | Clock-ratio error flag, forces mute control low |
| mute_req | input | 1 | 1 requests mute, 0 requests normal output |
| speed | input | 2 | 00 single, 01 double, 10/11 quad speed |
| smp_stb | input | 1 | One-cycle strobe per sample pair |
| in_l | input | 24 | Left sample, signed |
| in_r | input | 24 | Right sample, signed |
| out_l | output | 24 | Gain-scaled left sample |
| out_r | output | 24 | Gain-scaled right sample |
| mute_ctl_n | output | 1 | Active-low external mute control |

## Verification
The bench runs full ramps in each speed mode and checks the gain-scaled value on every strobe. A wrong step size or an off-by-one clamp would leave a nonzero sample at the expected end, or reach zero early. Mute control is sampled on the last ramp strobe and one clock later, so a design that asserts it from the request alone, or one cycle early, gets caught. A mid-ramp reversal checks the first step after the turn, so a design that restarts from unity or zero would fail. Strobe-free cycles with changing inputs expose a design that scales continuously.

// File: rtl/smr_pkg.sv
package smr_pkg;
  typedef enum logic [1:0] {
    SPD_SINGLE = 2'b00,
    SPD_DOUBLE = 2'b01,
    SPD_QUAD   = 2'b10,
    SPD_QUAD_X = 2'b11
  } speed_e;

  // Gain step per strobe; full scale is the quad-speed ramp length.
  function automatic logic [2:0] step_of(input logic [1:0] spd);
    case (speed_e'(spd))
      SPD_SINGLE: step_of = 3'd4;
      SPD_DOUBLE: step_of = 3'd2;
      default:    step_of = 3'd1;
    endcase
  endfunction
endpackage

// File: rtl/smr_ramp.sv
module smr_ramp #(
  parameter int RAMP_QUAD = 4608,
  localparam int LW = $clog2(RAMP_QUAD + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_stb,
  input  logic          mute_req,
  input  logic [1:0]    speed,
  output logic [LW-1:0] level_q,
  output logic [LW-1:0] level_d
);
  import smr_pkg::*;

  localparam logic [LW-1:0] FULL_L = LW'(RAMP_QUAD);

  logic [LW-1:0] step;

  always_comb begin
    step = LW'(step_of(speed));
    if (mute_req) begin
      level_d = (level_q > step) ? level_q - step : '0;
    end else begin
      level_d = ((FULL_L - level_q) > step) ? level_q + step : FULL_L;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= FULL_L;
    end else if (smp_stb) begin
      level_q <= level_d;
    end
  end
endmodule

// File: rtl/smr_scale.sv
module smr_scale #(
  parameter int DW = 24,
  parameter int RAMP_QUAD = 4608,
  localparam int LW = $clog2(RAMP_QUAD + 1),
  localparam int PW = DW + LW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic [LW-1:0]        level,
  input  logic signed [DW-1:0] din,
  output logic signed [DW-1:0] dout
);
  localparam logic signed [PW-1:0] FULL_S = PW'(RAMP_QUAD);

  logic signed [PW-1:0] din_x, lvl_x, prod, quo;
  logic signed [DW-1:0] dout_d;

  always_comb begin
    din_x  = PW'(din);
    lvl_x  = $signed(PW'(level));
    prod   = din_x * lvl_x;
    quo    = prod / FULL_S;
    dout_d = quo[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= '0;
    end else if (en) begin
      dout <= dout_d;
    end
  end
endmodule

// File: rtl/smr_mutec.sv
module smr_mutec (
  input  logic clk,
  input  logic rst_n,
  input  logic pdn,
  input  logic ratio_err,
  input  logic mute_req,
  input  logic lvl_zero,
  output logic mute_ctl_n
);
  logic ctl_d;

  always_comb begin
    ctl_d = !(pdn || ratio_err || (mute_req && lvl_zero));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mute_ctl_n <= 1'b0;
    end else begin
      mute_ctl_n <= ctl_d;
    end
  end
endmodule

// File: rtl/soft_mute_ramp.sv
module soft_mute_ramp #(
  parameter int DW = 24,
  parameter int RAMP_QUAD = 4608,
  localparam int LW = $clog2(RAMP_QUAD + 1),
  localparam int NCH = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pdn,
  input  logic                 ratio_err,
  input  logic                 mute_req,
  input  logic [1:0]           speed,
  input  logic                 smp_stb,
  input  logic signed [DW-1:0] in_l,
  input  logic signed [DW-1:0] in_r,
  output logic signed [DW-1:0] out_l,
  output logic signed [DW-1:0] out_r,
  output logic                 mute_ctl_n
);
  logic [LW-1:0] level_q, level_d;
  logic signed [DW-1:0] din_a  [NCH];
  logic signed [DW-1:0] dout_a [NCH];

  assign din_a[0] = in_l;
  assign din_a[1] = in_r;
  assign out_l    = dout_a[0];
  assign out_r    = dout_a[1];

  smr_ramp #(.RAMP_QUAD(RAMP_QUAD)) u_ramp (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .mute_req(mute_req),
    .speed(speed), .level_q(level_q), .level_d(level_d)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    smr_scale #(.DW(DW), .RAMP_QUAD(RAMP_QUAD)) u_scale (
      .clk(clk), .rst_n(rst_n), .en(smp_stb), .level(level_d),
      .din(din_a[g]), .dout(dout_a[g])
    );
  end

  smr_mutec u_mutec (
    .clk(clk), .rst_n(rst_n), .pdn(pdn), .ratio_err(ratio_err),
    .mute_req(mute_req), .lvl_zero(level_q == '0), .mute_ctl_n(mute_ctl_n)
  );
endmodule

// File: rtl/smr_chk.sv
module smr_chk #(
  parameter int DW = 24,
  parameter int RAMP_QUAD = 4608,
  localparam int LW = $clog2(RAMP_QUAD + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 pdn,
  input logic                 ratio_err,
  input logic                 mute_req,
  input logic                 smp_stb,
  input logic signed [DW-1:0] out_l,
  input logic signed [DW-1:0] out_r,
  input logic                 mute_ctl_n,
  input logic [LW-1:0]        level_q
);
  // R10
  hold_no_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_stb |=> ($stable(out_l) && $stable(out_r) && $stable(level_q)));

  // R7
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mute_req && !pdn && !ratio_err) |=> mute_ctl_n);

  // R8
  force_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pdn || ratio_err) |=> !mute_ctl_n);

  // R6
  no_early_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mute_req && level_q != '0 && !pdn && !ratio_err) |=> mute_ctl_n);

  // R5
  muted_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mute_req && smp_stb && level_q == '0) |=> (out_l == '0 && out_r == '0));

  // R3
  no_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((level_q >= $past(level_q)) ? (level_q - $past(level_q))
                                 : ($past(level_q) - level_q)) <= LW'(4));

  // R1
  level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level_q <= LW'(RAMP_QUAD));
endmodule

bind soft_mute_ramp smr_chk #(.DW(DW), .RAMP_QUAD(RAMP_QUAD)) u_chk (
  .clk(clk), .rst_n(rst_n), .pdn(pdn), .ratio_err(ratio_err),
  .mute_req(mute_req), .smp_stb(smp_stb), .out_l(out_l), .out_r(out_r),
  .mute_ctl_n(mute_ctl_n), .level_q(level_q)
);

// File: tb/sim_soft_mute_ramp.sv
module sim_soft_mute_ramp;
  localparam int FULL = 4608;

  logic clk = 1'b0;
  logic rst_n, pdn, ratio_err, mute_req, smp_stb;
  logic [1:0] speed;
  logic signed [23:0] in_l, in_r, out_l, out_r;
  logic mute_ctl_n;

  int nchk = 0;
  int nfail = 0;
  int lvl = FULL;
  bit done = 1'b0;

  always #10 clk = ~clk;

  soft_mute_ramp u0 (
    .clk(clk), .rst_n(rst_n), .pdn(pdn), .ratio_err(ratio_err),
    .mute_req(mute_req), .speed(speed), .smp_stb(smp_stb),
    .in_l(in_l), .in_r(in_r), .out_l(out_l), .out_r(out_r),
    .mute_ctl_n(mute_ctl_n)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic longint scaled(input logic signed [23:0] v, input int l);
    return (longint'(v) * l) / FULL;
  endfunction

  task automatic strobe(input logic signed [23:0] l, input logic signed [23:0] r);
    in_l = l; in_r = r; smp_stb = 1'b1;
    @(negedge clk);
    smp_stb = 1'b0;
  endtask

  // n strobes in the current direction, checking both outputs each time
  task automatic ramp(input int n, input int step, input string req);
    for (int k = 1; k <= n; k++) begin
      logic signed [23:0] v;
      v = 24'(k * 40961 + 5);
      if (mute_req) lvl = (lvl > step) ? lvl - step : 0;
      else          lvl = (FULL - lvl > step) ? lvl + step : FULL;
      strobe(v, -v);
      chk(req, out_l, scaled(v, lvl));
      chk(req, out_r, scaled(-v, lvl));
      chk({req, " mute_ctl_n high during ramp (R6)"}, mute_ctl_n, 1);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; pdn = 0; ratio_err = 0; mute_req = 0; smp_stb = 0;
    speed = 2'b00; in_l = 0; in_r = 0;
    repeat (3) @(negedge clk);
    chk("R8 mute_ctl_n in reset", mute_ctl_n, 0);
    chk("R9 out_l in reset", out_l, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 mute_ctl_n after reset", mute_ctl_n, 1);
    strobe(24'sd12345, -24'sd777);
    chk("R9 unity left", out_l, 12345);
    chk("R9 unity right", out_r, -777);
    strobe(24'sh7FFFFF, 24'sh800000);
    chk("R4 unity max", out_l, 8388607);
    chk("R4 unity min", out_r, -8388608);
  endtask

  task automatic t_single();
    speed = 2'b00; mute_req = 1'b1;
    ramp(1152, 4, "R1 single fade-out");
    chk("R1 level zero after 1152", lvl, 0);
    @(negedge clk);
    chk("R6 mute_ctl_n low after completion", mute_ctl_n, 0);
    strobe(24'sd999999, -24'sd5);
    chk("R5 muted out_l", out_l, 0);
    chk("R5 muted out_r", out_r, 0);
    mute_req = 1'b0;
    @(negedge clk);
    chk("R7 release on unmute", mute_ctl_n, 1);
    chk("R7 ramp not yet started", out_l, 0);
    ramp(1152, 4, "R1 single fade-in");
    chk("R1 level unity after 1152", lvl, FULL);
  endtask

  task automatic t_reverse();
    speed = 2'b00; mute_req = 1'b1;
    ramp(100, 4, "R3 pre-reversal");
    mute_req = 1'b0;
    ramp(1, 4, "R3 first step after reversal");
    chk("R3 level continues", lvl, 4212);
    ramp(99, 4, "R3 fade-in finish");
    strobe(24'sd4242, -24'sd1);
    chk("R3 back at unity", out_l, 4242);
  endtask

  task automatic t_double_quad();
    speed = 2'b01; mute_req = 1'b1;
    ramp(2303, 2, "R2 double fade-out");
    chk("R2 double not yet zero", lvl, 2);
    ramp(1, 2, "R2 double last step");
    @(negedge clk);
    chk("R2 double muted after 2304", mute_ctl_n, 0);
    mute_req = 1'b0;
    ramp(2304, 2, "R2 double fade-in");
    speed = 2'b10; mute_req = 1'b1;
    ramp(4608, 1, "R2 quad fade-out");
    @(negedge clk);
    chk("R2 quad muted after 4608", mute_ctl_n, 0);
    speed = 2'b11; mute_req = 1'b0;
    ramp(4608, 1, "R2 quad-alt fade-in");
    chk("R2 quad-alt unity", lvl, FULL);
  endtask

  task automatic t_force();
    pdn = 1'b1;
    @(negedge clk);
    chk("R8 pdn low", mute_ctl_n, 0);
    pdn = 1'b0;
    @(negedge clk);
    chk("R8 pdn release", mute_ctl_n, 1);
    ratio_err = 1'b1;
    @(negedge clk);
    chk("R8 ratio_err low", mute_ctl_n, 0);
    ratio_err = 1'b0;
    @(negedge clk);
    chk("R8 ratio_err release", mute_ctl_n, 1);
  endtask

  task automatic t_hold();
    logic signed [23:0] prev;
    strobe(24'sd300000, 24'sd7);
    prev = out_l;
    in_l = -24'sd5000; mute_req = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 out_l held without strobe", out_l, prev);
    mute_req = 1'b0;
    @(negedge clk);
    strobe(24'sd1000, 24'sd2000);
    chk("R10 level held without strobe", out_l, 1000);
  endtask

  initial begin
    t_reset();
    t_single();
    t_reverse();
    t_double_quad();
    t_force();
    t_hold();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule